// File: doc/BRIEF.md
# Dual-Lane Serial Converter Readout Controller

This block sits on the host side of a dual simultaneous-sampling 12-bit converter. The converter returns its two results on two serial lines. The controller drives four outputs toward the converter: a chip select, a channel address, a combined start-and-read strobe, and a conversion clock. It derives the conversion clock from the system clock with a counter. One request starts exactly one conversion frame. The frame lasts sixteen conversion-clock periods, and during it both lanes are shifted in side by side.

Each lane returns a 16-bit frame, first bit first. The first two bits are the lane's channel tags. The next twelve are the result, most significant bit first. The last two are a trailer that must read zero. When the frame ends, the controller gives a single-cycle valid pulse. With it come both 12-bit results, both tag pairs and a framing-error flag. These values then stay unchanged until the next pulse.

The conversion clock half-period is set by `HALF_DIV` in system clocks. It defaults to 16, which at a 250 MHz system clock gives a 128 ns conversion-clock period.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is asserted and right after it: `adc_cs_n` is 1, `adc_sclk` is 0, `adc_conv` is 0, `busy` is 0, `res_valid` is 0, and the results, tags and `frame_err` are 0.
- R2: A `start_req` seen while idle starts a frame. The frame is 16 `adc_sclk` periods of 2*HALF_DIV system cycles each, low half first. `res_valid` rises 32*HALF_DIV cycles after the accepting edge.
- R3: `adc_conv` (start and read joined) is high for exactly the first conversion-clock period of a frame, which is 2*HALF_DIV system cycles, and never outside a frame.
- R4: `adc_addr` takes the value of `chan_sel` at acceptance (1 selects channel 1, 0 selects channel 0). It does not change while `adc_cs_n` is low, so it is steady across the first falling clock edge.
- R5: Both lanes are sampled on every rising `adc_sclk` edge. Frame bit 1 goes to tag[1], bit 2 to tag[0], and bits 3 to 14 to the result, MSB first.
- R6: `res_valid` is a one-cycle pulse. It comes at the falling edge that closes period 16, in the same cycle as `adc_cs_n` returns high and `busy` falls.
- R7: `frame_err` is 1 with the valid pulse if frame bit 15 or 16 on either lane is 1. Otherwise it is 0.
- R8: A `start_req` seen while `busy` is high is ignored. It does not alter the address and it does not queue a frame.
- R9: The results, tags and `frame_err` hold their values between valid pulses.
- R10: `adc_sclk` is low whenever `adc_cs_n` is high, and `busy` equals the inverse of `adc_cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req | input | 1 | Conversion request, taken when idle |
| chan_sel | input | 1 | Channel to address for the requested conversion |
| adc_sclk | output | 1 | Conversion clock toward the converter |
| adc_conv | output | 1 | Combined conversion-start and read strobe |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_addr | output | 1 | Channel address toward the converter |
| sd_a | input | 1 | Serial data, lane A |
| sd_b | input | 1 | Serial data, lane B |
| busy | output | 1 | Frame in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data_a | output | DATA_W | Lane A result |
| res_data_b | output | DATA_W | Lane B result |
| res_tag_a | output | 2 | Lane A tag bits (first bit in bit 1) |
| res_tag_b | output | 2 | Lane B tag bits (first bit in bit 1) |
| frame_err | output | 1 | Trailer bit set on either lane |

## Verification
Some properties are checked on every cycle:
- chip select and busy stay consistent with each other;
- the clock is silent outside a frame;
- the start strobe stays inside the first period;
- the address holds for the whole frame;
- the valid pulse lasts one cycle and comes after exactly sixteen rising clock edges;
- results hold between pulses.

Other behaviour only the scenarios can show:
- bit-to-field mapping on both lanes, under several data and tag patterns;
- trailer-error detection per lane;
- the exact frame length and strobe width in system cycles;
- that a mid-frame request is dropped;
- recovery from a reset that arrives during a frame.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  localparam int TAG_W = 2;
  localparam int TRAIL_W = 2;
endpackage

// File: rtl/dadc_sclk_gen.sv
module dadc_sclk_gen #(
  parameter int HALF_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q == CW'(PERIOD - 1))
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Low half first, high half second; the counter rests at zero when idle.
  assign sclk      = (cnt_q >= CW'(HALF_DIV));
  assign rise_tick = run && (cnt_q == CW'(HALF_DIV - 1));
  assign fall_tick = run && (cnt_q == CW'(PERIOD - 1));
endmodule

// File: rtl/dadc_frame_seq.sv
module dadc_frame_seq
  import dadc_pkg::*;
#(
  parameter int FRAME_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic chan_sel,
  input  logic rise_tick,
  input  logic fall_tick,
  output logic active,
  output logic conv,
  output logic addr,
  output logic finish
);
  localparam int BW = $clog2(FRAME_LEN + 1);

  seq_state_t    st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          first_q, first_d;
  logic          addr_q, addr_d;

  assign finish = (st_q == SEQ_RUN) && fall_tick && (bit_q == BW'(FRAME_LEN));

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    first_d = first_q;
    addr_d  = addr_q;
    case (st_q)
      SEQ_IDLE: begin
        if (start_req) begin
          st_d    = SEQ_RUN;
          bit_d   = '0;
          first_d = 1'b1;
          addr_d  = chan_sel;
        end
      end
      default: begin
        if (rise_tick) bit_d = bit_q + 1'b1;
        if (fall_tick) first_d = 1'b0;
        if (finish)    st_d = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      bit_q   <= '0;
      first_q <= 1'b0;
      addr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      first_q <= first_d;
      addr_q  <= addr_d;
    end
  end

  assign active = (st_q == SEQ_RUN);
  assign conv   = active && first_q;
  assign addr   = addr_q;
endmodule

// File: rtl/dadc_lane_capture.sv
module dadc_lane_capture
  import dadc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd,
  input  logic              rise_tick,
  input  logic              load,
  output logic [DATA_W-1:0] data,
  output logic [TAG_W-1:0]  tag,
  output logic              trail_err
);
  localparam int FRAME_LEN = DATA_W + TAG_W + TRAIL_W;

  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    data_q;
  logic [TAG_W-1:0]     tag_q;
  logic                 err_q;

  assign sh_d = {sh_q[FRAME_LEN-2:0], sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh_q <= '0;
    else if (rise_tick) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      tag_q  <= sh_q[FRAME_LEN-1 -: TAG_W];
      data_q <= sh_q[TRAIL_W +: DATA_W];
      err_q  <= |sh_q[TRAIL_W-1:0];
    end
  end

  assign data      = data_q;
  assign tag       = tag_q;
  assign trail_err = err_q;
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import dadc_pkg::*;
#(
  parameter int HALF_DIV = 16,
  parameter int DATA_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              chan_sel,
  output logic              adc_sclk,
  output logic              adc_conv,
  output logic              adc_cs_n,
  output logic              adc_addr,
  input  logic              sd_a,
  input  logic              sd_b,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data_a,
  output logic [DATA_W-1:0] res_data_b,
  output logic [1:0]        res_tag_a,
  output logic [1:0]        res_tag_b,
  output logic              frame_err
);
  localparam int LANES     = 2;
  localparam int FRAME_LEN = DATA_W + TAG_W + TRAIL_W;

  logic active, rise_tick, fall_tick, finish, valid_q;
  logic [LANES-1:0]  lane_sd, lane_err;
  logic [DATA_W-1:0] lane_data [LANES];
  logic [TAG_W-1:0]  lane_tag  [LANES];

  dadc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(active),
    .sclk(adc_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  dadc_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .chan_sel(chan_sel),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .active(active), .conv(adc_conv), .addr(adc_addr), .finish(finish)
  );

  assign lane_sd = {sd_b, sd_a};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dadc_lane_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .sd(lane_sd[i]), .rise_tick(rise_tick),
      .load(finish), .data(lane_data[i]), .tag(lane_tag[i]),
      .trail_err(lane_err[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= finish;
  end

  assign adc_cs_n   = !active;
  assign busy       = active;
  assign res_valid  = valid_q;
  assign res_data_a = lane_data[0];
  assign res_data_b = lane_data[1];
  assign res_tag_a  = lane_tag[0];
  assign res_tag_b  = lane_tag[1];
  assign frame_err  = |lane_err;
endmodule

// File: rtl/dadc_checker.sv
module dadc_checker #(
  parameter int HALF_DIV = 16,
  parameter int DATA_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_sclk,
  input logic              adc_conv,
  input logic              adc_cs_n,
  input logic              adc_addr,
  input logic              busy,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data_a,
  input logic [DATA_W-1:0] res_data_b,
  input logic [1:0]        res_tag_a,
  input logic [1:0]        res_tag_b,
  input logic              frame_err
);
  localparam int FRAME_LEN = DATA_W + 4;

  logic       sclk_d;
  logic [7:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      rises_q <= '0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_cs_n && !res_valid)    rises_q <= '0;
      else if (adc_sclk && !sclk_d)  rises_q <= rises_q + 1'b1;
    end
  end

  a_r10_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  a_r10_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !adc_cs_n);
  a_r3_conv_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> (!adc_cs_n && rises_q <= 8'd1));
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_addr));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r6_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> adc_cs_n);
  a_r2_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rises_q == 8'(FRAME_LEN)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({res_data_a, res_data_b, res_tag_a, res_tag_b, frame_err}));
endmodule

bind dual_adc_reader dadc_checker #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dual_adc_reader.sv
`timescale 1ns/1ps
module tb_dual_adc_reader;
  localparam int HALF = 16;
  localparam int NV = 7;

  logic clk = 1'b0, rst_n, start_req, chan_sel, sd_a, sd_b;
  logic adc_sclk, adc_conv, adc_cs_n, adc_addr, busy, res_valid, frame_err;
  logic [11:0] res_data_a, res_data_b;
  logic [1:0]  res_tag_a, res_tag_b;

  int total = 0, fails = 0;
  int rises = 0, convc = 0, vcount = 0, idx = 0;
  logic addr_seen;
  logic [15:0] fa, fb;

  // {chan, lane A frame, lane B frame}; frame = {tag(2), data(12), trailer(2)}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 2'b00, 12'h000, 2'b00, 2'b11, 12'hFFF, 2'b00},
    {1'b1, 2'b10, 12'hABC, 2'b00, 2'b01, 12'h123, 2'b00},
    {1'b0, 2'b01, 12'h800, 2'b00, 2'b10, 12'h001, 2'b00},
    {1'b1, 2'b11, 12'h555, 2'b01, 2'b00, 12'hAAA, 2'b00},
    {1'b0, 2'b00, 12'h0F0, 2'b00, 2'b11, 12'hF0F, 2'b10},
    {1'b1, 2'b10, 12'hFFF, 2'b11, 2'b01, 12'h000, 2'b11},
    {1'b1, 2'b01, 12'h7FE, 2'b00, 2'b10, 12'h801, 2'b00}
  };

  always #2 clk = ~clk;

  dual_adc_reader dut (.*);

  // Converter model: bit 1 appears when chip select falls, next bit on each falling clock.
  always @(negedge adc_cs_n) begin
    idx = 0; sd_a = fa[15]; sd_b = fb[15];
  end
  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      if (idx == 0) addr_seen = adc_addr;
      idx = idx + 1;
      if (idx < 16) begin sd_a = fa[15-idx]; sd_b = fb[15-idx]; end
    end
  end
  always @(posedge adc_sclk) if (!adc_cs_n) rises++;
  always @(posedge clk) begin
    if (adc_conv) convc++;
    if (res_valid) vcount++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic ch, input logic [15:0] a, input logic [15:0] b,
                           input bit mid_req, output int cyc);
    fa = a; fb = b; rises = 0; convc = 0; addr_seen = 1'bx;
    @(negedge clk); chan_sel = ch; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0; chan_sel = 1'bx;
    cyc = 0;
    while (!res_valid && cyc < 2000) begin
      if (mid_req && cyc == 100) begin chan_sel = !ch; start_req = 1'b1; end
      if (mid_req && cyc == 101) start_req = 1'b0;
      @(negedge clk); cyc++;
    end
  endtask

  initial begin
    #600000;
    total++; fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start_req = 1'b0; chan_sel = 1'b0; sd_a = 1'b0; sd_b = 1'b0;
    fa = '0; fb = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", adc_cs_n, 1); chk("R1 sclk", adc_sclk, 0);
    chk("R1 conv", adc_conv, 0); chk("R1 busy", busy, 0);
    chk("R1 valid", res_valid, 0);
    chk("R1 results", {res_data_a, res_data_b, res_tag_a, res_tag_b, frame_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] a, b;
      a = VEC[v][31:16]; b = VEC[v][15:0];
      run_frame(VEC[v][32], a, b, 1'b0, cyc);
      chk("R2 frame length", cyc, 32 * HALF);
      chk("R2 rising edges", rises, 16);
      chk("R3 conv width", convc, 2 * HALF);
      chk("R4 address", addr_seen, VEC[v][32]);
      chk("R5 data A", res_data_a, a[13:2]);
      chk("R5 data B", res_data_b, b[13:2]);
      chk("R5 tag A", res_tag_a, a[15:14]);
      chk("R5 tag B", res_tag_b, b[15:14]);
      chk("R7 trailer", frame_err, (|a[1:0]) | (|b[1:0]));
      chk("R6 cs_n at valid", adc_cs_n, 1);
      chk("R6 busy at valid", busy, 0);
      @(negedge clk);
      chk("R6 one-cycle valid", res_valid, 0);
    end

    // R8: request during a frame is ignored; R9: results hold afterwards
    vcount = 0;
    run_frame(1'b1, {2'b10, 12'h3C5, 2'b00}, {2'b01, 12'hC3A, 2'b00}, 1'b1, cyc);
    chk("R8 address kept", addr_seen, 1);
    chk("R8 frame length", cyc, 32 * HALF);
    repeat (4 * HALF) @(negedge clk);
    chk("R8 no queued frame busy", busy, 0);
    chk("R8 no queued frame cs_n", adc_cs_n, 1);
    chk("R8 single valid", vcount, 1);
    chk("R9 data held", {res_data_a, res_data_b}, {12'h3C5, 12'hC3A});
    chk("R9 tags held", {res_tag_a, res_tag_b}, 4'b1001);
    chk("R10 sclk idle", adc_sclk, 0);

    // Reset in the middle of a frame, then recovery
    fa = {2'b11, 12'h999, 2'b00}; fb = fa;
    @(negedge clk); chan_sel = 1'b1; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (150) @(negedge clk);
    chk("R10 busy mid frame", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 cs_n after reset", adc_cs_n, 1);
    chk("R1 sclk after reset", adc_sclk, 0);
    chk("R1 data after reset", {res_data_a, res_data_b, frame_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(1'b0, {2'b01, 12'h246, 2'b00}, {2'b10, 12'h9BD, 2'b01}, 1'b0, cyc);
    chk("R2 recovery length", cyc, 32 * HALF);
    chk("R5 recovery data", {res_data_a, res_data_b}, {12'h246, 12'h9BD});
    chk("R7 lane B trailer", frame_err, 1);
    chk("R4 recovery address", addr_seen, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule